// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block is the register file that software sees for a two-channel bus-master DMA engine on a storage controller. It sits on a simple byte-addressed I/O port. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. A port access moves 1, 2 or 4 bytes. The data is right-aligned: data byte k lands on window offset `addr+k`, and the offset wraps inside the channel's 8-byte window.

The block sends the start and direction bits and the table pointer to the DMA engine. It takes back one-cycle error and interrupt pulses from the engine. The status byte holds three kinds of bit:
- plain read/write bits;
- a busy flag that is owned by hardware;
- sticky event bits that software clears by writing a one.

Each channel has a small two-state machine. In `CH_IDLE` the engine is stopped and the busy flag reads 0. In `CH_RUN` the engine is started and the busy flag reads 1. There are two transitions, and both happen only on a command write:
- `GO` moves `CH_IDLE` to `CH_RUN` when the written start bit is 1.
- `HALT` moves `CH_RUN` to `CH_IDLE` when the written start bit is 0.

Any other access leaves the state where it is.

Top module: `bmdma_regfile`

## Requirements
- R1: Channel c occupies addresses 8c to 8c+7. Within a window, offset 0 is command, offset 2 is status, and offsets 4 to 7 hold the pointer, least significant byte first. The size code gives the access width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 mean 4 bytes. Data byte k maps to window offset (addr+k) mod 8. A read returns zero in data lanes beyond the access width.
- R2: A read of offset 1 or 3 returns 8'hFF, and a write to those offsets changes nothing.
- R3: In the command byte, bit 0 (start) and bit 3 (direction) are stored and appear on `eng_start` and `eng_dir`. The other command bits read 0.
- R4: Status bit 0 reads 1 exactly while the channel is in `CH_RUN`. A status write never changes it.
- R5: Status bits 5 and 6 take the value written to them.
- R6: Writing a one to status bit 1 or bit 2 clears that bit. Writing a zero leaves it unchanged.
- R7: Status bits 3, 4 and 7 always read 0.
- R8: An `eng_err` pulse sets status bit 1 and an `eng_irq` pulse sets status bit 2. If the pulse arrives in the same cycle as a write-one-to-clear, the bit ends up set.
- R9: A pointer write changes only the bytes it addresses. Pointer bits 1:0 are always stored as 0. The stored pointer appears on `eng_tbl_ptr`.
- R10: Reset clears command, status and pointer in every channel.
- R11: An access to one channel leaves the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_addr | input | ADDR_W (4) | Byte address: channel in the upper bits, window offset in bits 2:0 |
| io_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| io_wdata | input | 32 | Write data, right-aligned |
| io_rdata | output | 32 | Combinational read data, right-aligned |
| eng_err | input | NUM_CH | Error pulses from the engine, one per channel |
| eng_irq | input | NUM_CH | Interrupt pulses from the engine, one per channel |
| eng_start | output | NUM_CH | Start bit of each channel |
| eng_dir | output | NUM_CH | Direction bit of each channel |
| eng_tbl_ptr | output | 32*NUM_CH | Descriptor-table pointer of each channel |

## Verification
The bench uses the default of two channels. That makes the 4-bit address space small enough to sweep completely.

- Every byte address is read at every access width. This also covers accesses that wrap inside a window.
- All 256 status write values are applied on both channels, each after the event bits have been set and a command value has been written.
- Every combination of clear mask and same-cycle event pulse is checked.
- Every pointer offset is written at every width, and the result is checked against a byte model kept in the bench.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int unsigned WIN_BYTES = 8;
    localparam int unsigned LANES     = 4;
    localparam logic [2:0]  OFF_CMD   = 3'd0;
    localparam logic [2:0]  OFF_STAT  = 3'd2;
    localparam logic [2:0]  OFF_PTR0  = 3'd4;
    localparam logic [7:0]  PAD_BYTE  = 8'hFF;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bmdma_lane_decode.sv
module bmdma_lane_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 3
) (
    input  logic                          io_wr,
    input  logic [ADDR_W-1:0]             io_addr,
    input  logic [1:0]                    io_size,
    input  logic [31:0]                   io_wdata,
    output logic [CH_W-1:0]               ch_sel,
    output logic [LANES-1:0]              lane_en,
    output logic [LANES-1:0][2:0]         lane_off,
    output logic [NUM_CH-1:0][WIN_BYTES-1:0] byte_we,
    output logic [WIN_BYTES-1:0][7:0]     byte_wd
);
    logic [2:0] nbytes;

    assign ch_sel = io_addr[ADDR_W-1:3];
    assign nbytes = size_to_bytes(io_size);

    always_comb begin
        byte_we = '0;
        byte_wd = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_en[k]  = (3'(k) < nbytes);
            lane_off[k] = io_addr[2:0] + 3'(k);
            if (io_wr && lane_en[k]) begin
                byte_we[ch_sel][lane_off[k]] = 1'b1;
                byte_wd[lane_off[k]]         = io_wdata[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WIN_BYTES-1:0]       byte_we,
    input  logic [WIN_BYTES-1:0][7:0]  byte_wd,
    input  logic                       ev_err,
    input  logic                       ev_irq,
    output logic [WIN_BYTES-1:0][7:0]  rd_bytes,
    output logic                       start,
    output logic                       dir,
    output logic [31:0]                tbl_ptr
);
    ch_state_e  state, state_nx;
    logic       cmd_we, stat_we;
    logic       dir_q, err_q, irq_q;
    logic [1:0] user_q;

    assign cmd_we  = byte_we[OFF_CMD];
    assign stat_we = byte_we[OFF_STAT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // transitions GO and HALT
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (cmd_we && byte_wd[OFF_CMD][0])  state_nx = CH_RUN;
            CH_RUN:  if (cmd_we && !byte_wd[OFF_CMD][0]) state_nx = CH_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        start = 1'b0;
        unique case (state)
            CH_IDLE: start = 1'b0;
            CH_RUN:  start = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            user_q <= 2'b00;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (cmd_we)  dir_q  <= byte_wd[OFF_CMD][3];
            if (stat_we) user_q <= byte_wd[OFF_STAT][6:5];
            err_q <= ev_err | (err_q & ~(stat_we & byte_wd[OFF_STAT][1]));
            irq_q <= ev_irq | (irq_q & ~(stat_we & byte_wd[OFF_STAT][2]));
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_ptr
        localparam logic [7:0] KEEP = (g == 0) ? 8'hFC : 8'hFF;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       tbl_ptr[8*g +: 8] <= 8'h00;
            else if (byte_we[OFF_PTR0 + g])   tbl_ptr[8*g +: 8] <= byte_wd[OFF_PTR0 + g] & KEEP;
        end
    end

    assign dir = dir_q;

    always_comb begin
        rd_bytes[0] = {4'b0000, dir_q, 2'b00, start};
        rd_bytes[1] = PAD_BYTE;
        rd_bytes[2] = {1'b0, user_q, 2'b00, irq_q, err_q, start};
        rd_bytes[3] = PAD_BYTE;
        for (int b = 0; b < 4; b++) rd_bytes[4 + b] = tbl_ptr[8*b +: 8];
    end

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [1:0]           io_size,
    input  logic [31:0]          io_wdata,
    output logic [31:0]          io_rdata,
    input  logic [NUM_CH-1:0]    eng_err,
    input  logic [NUM_CH-1:0]    eng_irq,
    output logic [NUM_CH-1:0]    eng_start,
    output logic [NUM_CH-1:0]    eng_dir,
    output logic [32*NUM_CH-1:0] eng_tbl_ptr
);
    logic [CH_W-1:0]                      ch_sel;
    logic [LANES-1:0]                     lane_en;
    logic [LANES-1:0][2:0]                lane_off;
    logic [NUM_CH-1:0][WIN_BYTES-1:0]     byte_we;
    logic [WIN_BYTES-1:0][7:0]            byte_wd;
    logic [NUM_CH-1:0][WIN_BYTES-1:0][7:0] ch_bytes;

    bmdma_lane_decode #(.NUM_CH(NUM_CH)) dec_i (
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_size  (io_size),
        .io_wdata (io_wdata),
        .ch_sel   (ch_sel),
        .lane_en  (lane_en),
        .lane_off (lane_off),
        .byte_we  (byte_we),
        .byte_wd  (byte_wd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bmdma_channel ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .byte_we  (byte_we[c]),
            .byte_wd  (byte_wd),
            .ev_err   (eng_err[c]),
            .ev_irq   (eng_irq[c]),
            .rd_bytes (ch_bytes[c]),
            .start    (eng_start[c]),
            .dir      (eng_dir[c]),
            .tbl_ptr  (eng_tbl_ptr[32*c +: 32])
        );
    end

    always_comb begin
        for (int k = 0; k < LANES; k++)
            io_rdata[8*k +: 8] = lane_en[k] ? ch_bytes[ch_sel][lane_off[k]] : 8'h00;
    end

endmodule

// File: rtl/bmdma_regfile_sva.sv
module bmdma_regfile_sva #(
    parameter int NUM_CH = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_wr,
    input logic [ADDR_W-1:0]    io_addr,
    input logic [1:0]           io_size,
    input logic [31:0]          io_wdata,
    input logic [31:0]          io_rdata,
    input logic [NUM_CH-1:0]    eng_start,
    input logic [NUM_CH-1:0]    eng_dir,
    input logic [32*NUM_CH-1:0] eng_tbl_ptr
);
    localparam logic [ADDR_W-1:0] A_CMD0  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_PTR0  = ADDR_W'(4);

    assert_start_follows_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_CMD0) |=> eng_start[0] == $past(io_wdata[0]));

    assert_dir_follows_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_CMD0) |=> eng_dir[0] == $past(io_wdata[3]));

    assert_ptr_dword_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_PTR0 && io_size == 2'd2)
            |=> eng_tbl_ptr[31:0] == {$past(io_wdata[31:2]), 2'b00});

    assert_pad_reads_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[2:0] == 3'd1 || io_addr[2:0] == 3'd3) |-> io_rdata[7:0] == 8'hFF);

    assert_busy_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == A_STAT0) |-> io_rdata[0] == eng_start[0]);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[2:0] == 3'd2) |-> (io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b00));

    assert_engine_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(eng_start) && $stable(eng_dir) && $stable(eng_tbl_ptr)));

endmodule

bind bmdma_regfile bmdma_regfile_sva #(.NUM_CH(NUM_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .io_size     (io_size),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .eng_start   (eng_start),
    .eng_dir     (eng_dir),
    .eng_tbl_ptr (eng_tbl_ptr)
);

// File: tb/bmdma_regfile_tb_top.sv
`timescale 1ns/1ps
module bmdma_regfile_tb_top;
    localparam int NCH = 2;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            io_wr = 1'b0;
    logic [AW-1:0]   io_addr = '0;
    logic [1:0]      io_size = '0;
    logic [31:0]     io_wdata = '0;
    logic [31:0]     io_rdata;
    logic [NCH-1:0]  eng_err = '0;
    logic [NCH-1:0]  eng_irq = '0;
    logic [NCH-1:0]  eng_start;
    logic [NCH-1:0]  eng_dir;
    logic [32*NCH-1:0] eng_tbl_ptr;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic       m_start [NCH];
    logic       m_dir   [NCH];
    logic       m_err   [NCH];
    logic       m_irq   [NCH];
    logic [1:0] m_user  [NCH];
    logic [7:0] m_ptr   [NCH][4];

    always #4 clk = ~clk;

    bmdma_regfile #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .eng_err(eng_err), .eng_irq(eng_irq), .eng_start(eng_start),
        .eng_dir(eng_dir), .eng_tbl_ptr(eng_tbl_ptr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] exp_byte(input int c, input int o);
        case (o)
            0: return {4'b0, m_dir[c], 2'b00, m_start[c]};
            1, 3: return 8'hFF;
            2: return {1'b0, m_user[c], 2'b00, m_irq[c], m_err[c], m_start[c]};
            default: return m_ptr[c][o-4];
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_start[c] = 0; m_dir[c] = 0; m_err[c] = 0; m_irq[c] = 0; m_user[c] = 0;
            for (int b = 0; b < 4; b++) m_ptr[c][b] = 8'h00;
        end
    endtask

    task automatic do_write(input int c, input int o, input logic [1:0] sz, input logic [31:0] d,
                            input logic ep, input logic ip);
        @(negedge clk);
        io_wr = 1; io_addr = AW'(c*8 + o); io_size = sz; io_wdata = d;
        eng_err[c] = ep; eng_irq[c] = ip;
        @(negedge clk);
        io_wr = 0; eng_err = '0; eng_irq = '0;
        for (int k = 0; k < nbytes(sz); k++) begin
            int t = (o + k) % 8;
            logic [7:0] v = d[8*k +: 8];
            case (t)
                0: begin m_start[c] = v[0]; m_dir[c] = v[3]; end
                2: begin
                    m_user[c] = v[6:5];
                    m_err[c]  = m_err[c] & ~v[1];
                    m_irq[c]  = m_irq[c] & ~v[2];
                end
                4: m_ptr[c][0] = v & 8'hFC;
                5, 6, 7: m_ptr[c][t-4] = v;
                default: ;
            endcase
        end
        if (ep) m_err[c] = 1;
        if (ip) m_irq[c] = 1;
    endtask

    task automatic pulse(input int c, input logic ep, input logic ip);
        @(negedge clk);
        eng_err[c] = ep; eng_irq[c] = ip;
        @(negedge clk);
        eng_err = '0; eng_irq = '0;
        if (ep) m_err[c] = 1;
        if (ip) m_irq[c] = 1;
    endtask

    task automatic check_read(input int c, input int o, input logic [1:0] sz, input string req);
        logic [31:0] e = '0;
        io_addr = AW'(c*8 + o); io_size = sz;
        for (int k = 0; k < nbytes(sz); k++) e[8*k +: 8] = exp_byte(c, (o + k) % 8);
        #1;
        chk(io_rdata === e, req, io_rdata, e);
    endtask

    task automatic check_eng(input string req);
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] p = {m_ptr[c][3], m_ptr[c][2], m_ptr[c][1], m_ptr[c][0]};
            chk(eng_start[c] === m_start[c], req, 32'(eng_start[c]), 32'(m_start[c]));
            chk(eng_dir[c] === m_dir[c], req, 32'(eng_dir[c]), 32'(m_dir[c]));
            chk(eng_tbl_ptr[32*c +: 32] === p, req, eng_tbl_ptr[32*c +: 32], p);
        end
    endtask

    initial begin
        #(8.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10: reset state seen on every byte and on the engine side
        for (int c = 0; c < NCH; c++)
            for (int o = 0; o < 8; o++) check_read(c, o, 2'd0, "R10 reset byte");
        check_eng("R10 reset engine");

        // R4 R5 R6 R7 R3: every status value after events and a command write
        for (int c = 0; c < NCH; c++) begin
            for (int v = 0; v < 256; v++) begin
                pulse(c, 1'b1, 1'b1);
                do_write(c, 0, 2'd0, 32'(v ^ 8'h5A), 1'b0, 1'b0);
                check_read(c, 0, 2'd0, "R3 command byte");
                do_write(c, 2, 2'd0, 32'(v), 1'b0, 1'b0);
                check_read(c, 2, 2'd0, "R4 R5 R6 R7 status byte");
            end
            check_eng("R3 engine outputs");
        end

        // R8: set pulse against write-one-to-clear in the same cycle
        for (int c = 0; c < NCH; c++)
            for (int clr = 0; clr < 4; clr++)
                for (int p = 0; p < 4; p++) begin
                    pulse(c, 1'b1, 1'b1);
                    do_write(c, 2, 2'd0, 32'(clr << 1), p[0], p[1]);
                    check_read(c, 2, 2'd0, "R8 set wins over clear");
                end

        // R9 R1 R11: pointer writes at every offset and width, incl. wrap
        for (int c = 0; c < NCH; c++)
            for (int sz = 0; sz < 3; sz++)
                for (int o = 4; o < 8; o++) begin
                    logic [31:0] d = 32'h9E3779B9 * 32'(c*97 + sz*13 + o + 1);
                    do_write(c, o, 2'(sz), d, 1'b0, 1'b0);
                    check_read(c, 4, 2'd2, "R9 pointer dword");
                    check_read(1 - c, 4, 2'd2, "R11 other channel pointer");
                    check_eng("R9 engine pointer");
                end

        // R2: writes to pad offsets change nothing
        for (int c = 0; c < NCH; c++) begin
            do_write(c, 1, 2'd0, 32'h00, 1'b0, 1'b0);
            do_write(c, 3, 2'd0, 32'h00, 1'b0, 1'b0);
            for (int o = 0; o < 8; o++) check_read(c, o, 2'd0, "R2 pad write ignored");
        end

        // R1: read sweep over every address and width (size 3 reads 4 bytes)
        for (int c = 0; c < NCH; c++)
            for (int o = 0; o < 8; o++)
                for (int sz = 0; sz < 4; sz++) check_read(c, o, 2'(sz), "R1 read lanes");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule